// File: doc/BRIEF.md
# Prioritised Interrupt Distributor

This block gathers a set of peripheral interrupt lines, 64 by default, and holds per-line state for each of them: enable, pending, active, group, a 5-bit priority and a trigger type. Software reaches that state over a simple word-addressed register bus. Enable, pending and active each have a set register and a clear register. Writing a 1 to a bit changes the matching state, and writing a 0 leaves it alone. Each line can be configured as level-sensitive or rising-edge-sensitive. Inputs pass through a synchronizer before any trigger logic sees them.

In every cycle the block selects, per group, the best line that is pending, enabled and not active. Group 0 drives the FIQ request and group 1 drives the IRQ request, and each request comes with the winning line's ID. The CPU side acknowledges the presented interrupt of one group, which moves that line from pending to active. It later signals end of interrupt with the line's ID, which clears active again.

The bus address is a word address. Bits [9:6] select a region and bits [5:0] select a word within it:

| Region code | Region |
| --- | --- |
| 0 | control |
| 1 | group |
| 2 | set-enable |
| 3 | clear-enable |
| 4 | set-pending |
| 5 | clear-pending |
| 6 | set-active |
| 7 | clear-active |
| 8 | priority |
| 9 | trigger config |

`NUM_LINES` must be a multiple of 32 and at most 224.

Top module: `intr_distributor`

## Requirements
- R1: After reset every line is disabled, not pending and not active, with priority 0, group 0 and level trigger. Both group enables are 0. `fiqReq` and `irqReq` are low, `fiqId` and `irqId` hold the all-ones spurious value (127 for 64 lines), and every readback is 0.
- R2: For enable, a write to set-enable word w (region 2) sets the enable of each line 32w+b whose data bit b is 1. A write to clear-enable word w (region 3) clears those enables. Zero bits have no effect, and a read of either region returns the current enables.
- R3: Pending (regions 4 and 5) and active (regions 6 and 7) follow the same set/clear pairing as enable, and a read of either region of a pair returns the current state.
- R4: Priority word w (region 8) holds lines 4w to 4w+3. Line 4w+k takes byte lane k, with the priority in bits [8k+4:8k] and bits [8k+7:8k+5] reading 0.
- R5: Among the candidates of a group, the lowest priority value wins. Ties go to the lowest line ID.
- R6: Group word w (region 1) bit b places line 32w+b in group 0 (value 0, FIQ output) or group 1 (value 1, IRQ output). Control word 0 (region 0) bit 0 enables group 0 and bit 1 enables group 1. A disabled group keeps its request low and its ID at the spurious value.
- R7: Config word w (region 9) bit 2k+1 set makes line 16w+k rising-edge triggered. Bit 2k always reads 0. On an edge line, a rising edge of the synchronized input sets pending, and pending stays set after the input falls.
- R8: On a level line, pending reads 1 and requests while the synchronized input is high. A clear-pending write has no lasting effect while the input stays high. Once the input falls, pending reads 0.
- R9: `ackValid` with `ackGroup` (0 = FIQ, 1 = IRQ) acknowledges the line that group is presenting: it becomes active and its pending is cleared. An active line is not offered again, even if it becomes pending, until end of interrupt.
- R10: `eoiValid` with `eoiId` clears the active bit of that line, after which it may be offered again.
- R11: A state change made on a clock edge appears on the request and ID outputs at the following edge.
- R12: A disabled line is never offered, even while its pending bit is set.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_LINES | Peripheral interrupt lines, asynchronous |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Word address: region [9:6], word [5:0] |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read |
| ackValid | input | 1 | Acknowledge the presented interrupt |
| ackGroup | input | 1 | Group acknowledged: 0 FIQ, 1 IRQ |
| eoiValid | input | 1 | End of interrupt |
| eoiId | input | ID_W | Line ID ending service |
| fiqReq | output | 1 | Group 0 request |
| fiqId | output | ID_W | Group 0 winning ID or all-ones |
| irqReq | output | 1 | Group 1 request |
| irqId | output | ID_W | Group 1 winning ID or all-ones |

## Verification
The bench sets up equal priorities on lines 9 and 40 and checks that line 9 wins. A design that broke ties the wrong way would present 40. It writes a clear-pending while a level input is still high and expects pending to read back 1. A design that let the clear win would lose a level interrupt that is still asserted. It re-pends an active line and checks that the lower-priority line stays presented until end of interrupt, which catches re-offering of lines already in service. It also reads priority and config words written with all ones, which exposes stored reserved bits.

// File: rtl/intr_dist_pkg.sv
package intr_dist_pkg;

  localparam logic [3:0] RG_CTRL    = 4'd0;
  localparam logic [3:0] RG_GROUP   = 4'd1;
  localparam logic [3:0] RG_SETEN   = 4'd2;
  localparam logic [3:0] RG_CLREN   = 4'd3;
  localparam logic [3:0] RG_SETPEND = 4'd4;
  localparam logic [3:0] RG_CLRPEND = 4'd5;
  localparam logic [3:0] RG_SETACT  = 4'd6;
  localparam logic [3:0] RG_CLRACT  = 4'd7;
  localparam logic [3:0] RG_PRIO    = 4'd8;
  localparam logic [3:0] RG_CFG     = 4'd9;

  // strobes from the control decoder to the state datapath
  typedef struct packed {
    logic       wrCtrl;
    logic       wrGroup;
    logic       wrSetEn;
    logic       wrClrEn;
    logic       wrSetPend;
    logic       wrClrPend;
    logic       wrSetAct;
    logic       wrClrAct;
    logic       wrPrio;
    logic       wrCfg;
    logic       rdEn;
    logic [3:0] rdRegion;
    logic [5:0] word;
    logic       ackDo;
    logic [7:0] ackLine;
    logic       eoiDo;
    logic [7:0] eoiLine;
  } regStrobeT;

endpackage

// File: rtl/intr_dist_ctrl.sv
module intr_dist_ctrl
  import intr_dist_pkg::*;
#(
  parameter int ID_W = 7
) (
  input  logic            busValid,
  input  logic            busWrite,
  input  logic [9:0]      busAddr,
  input  logic            ackValid,
  input  logic            ackGroup,
  input  logic            fiqReq,
  input  logic [ID_W-1:0] fiqId,
  input  logic            irqReq,
  input  logic [ID_W-1:0] irqId,
  input  logic            eoiValid,
  input  logic [ID_W-1:0] eoiId,
  output regStrobeT       strobe
);

  logic [3:0] region;
  logic       doWrite;

  always_comb begin
    region  = busAddr[9:6];
    doWrite = busValid & busWrite;
    strobe  = '0;
    strobe.word     = busAddr[5:0];
    strobe.rdRegion = region;
    strobe.rdEn     = busValid & ~busWrite;
    if (doWrite) begin
      case (region)
        RG_CTRL:    strobe.wrCtrl    = 1'b1;
        RG_GROUP:   strobe.wrGroup   = 1'b1;
        RG_SETEN:   strobe.wrSetEn   = 1'b1;
        RG_CLREN:   strobe.wrClrEn   = 1'b1;
        RG_SETPEND: strobe.wrSetPend = 1'b1;
        RG_CLRPEND: strobe.wrClrPend = 1'b1;
        RG_SETACT:  strobe.wrSetAct  = 1'b1;
        RG_CLRACT:  strobe.wrClrAct  = 1'b1;
        RG_PRIO:    strobe.wrPrio    = 1'b1;
        RG_CFG:     strobe.wrCfg     = 1'b1;
        default:    ;
      endcase
    end
    // acknowledge only takes the group's presented line when it is requesting
    strobe.ackDo   = ackValid & (ackGroup ? irqReq : fiqReq);
    strobe.ackLine = 8'(ackGroup ? irqId : fiqId);
    strobe.eoiDo   = eoiValid;
    strobe.eoiLine = 8'(eoiId);
  end

endmodule

// File: rtl/intr_dist_state.sv
module intr_dist_state
  import intr_dist_pkg::*;
#(
  parameter int NUM_LINES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  regStrobeT            strobe,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic [1:0]           ctrlEn,
  output logic [NUM_LINES-1:0] enBits,
  output logic [NUM_LINES-1:0] pendBits,
  output logic [NUM_LINES-1:0] actBits,
  output logic [NUM_LINES-1:0] grpBits,
  output logic [4:0]           prioVal [NUM_LINES]
);

  localparam int WORDS32    = NUM_LINES / 32;
  localparam int PRIO_WORDS = NUM_LINES / 4;
  localparam int CFG_WORDS  = NUM_LINES / 16;

  logic [NUM_LINES-1:0] syncReg [SYNC_STAGES];
  logic [NUM_LINES-1:0] levelNow, levelPrev, riseNow;
  logic [NUM_LINES-1:0] latchBits, edgeSel;
  logic [NUM_LINES-1:0] enNext, latchNext, actNext, grpNext, edgeNext;
  logic [4:0]           prioNext [NUM_LINES];

  // input synchronizer and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncReg[s] <= '0;
      levelPrev <= '0;
    end else begin
      syncReg[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncReg[s] <= syncReg[s-1];
      levelPrev <= levelNow;
    end
  end

  assign levelNow = syncReg[SYNC_STAGES-1];
  assign riseNow  = levelNow & ~levelPrev;
  // level lines show the live input on top of the latched pending bit
  assign pendBits = latchBits | (levelNow & ~edgeSel);

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic wordHit, prioHit, cfgHit, ackHit, eoiHit, dataBit;
    assign wordHit = strobe.word == 6'(i / 32);
    assign prioHit = strobe.wrPrio && (strobe.word == 6'(i / 4));
    assign cfgHit  = strobe.wrCfg && (strobe.word == 6'(i / 16));
    assign dataBit = wrData[i % 32];
    assign ackHit  = strobe.ackDo && (strobe.ackLine == 8'(i));
    assign eoiHit  = strobe.eoiDo && (strobe.eoiLine == 8'(i));

    assign enNext[i] = (enBits[i] & ~(strobe.wrClrEn & wordHit & dataBit))
                     | (strobe.wrSetEn & wordHit & dataBit);
    assign latchNext[i] = (latchBits[i] & ~(strobe.wrClrPend & wordHit & dataBit) & ~ackHit)
                        | (strobe.wrSetPend & wordHit & dataBit)
                        | (edgeSel[i] & riseNow[i]);
    assign actNext[i] = (actBits[i] & ~(strobe.wrClrAct & wordHit & dataBit) & ~eoiHit)
                      | (strobe.wrSetAct & wordHit & dataBit)
                      | ackHit;
    assign grpNext[i]  = (strobe.wrGroup & wordHit) ? dataBit : grpBits[i];
    assign edgeNext[i] = cfgHit ? wrData[(i % 16) * 2 + 1] : edgeSel[i];
    assign prioNext[i] = prioHit ? wrData[(i % 4) * 8 +: 5] : prioVal[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn    <= '0;
      enBits    <= '0;
      latchBits <= '0;
      actBits   <= '0;
      grpBits   <= '0;
      edgeSel   <= '0;
      for (int i = 0; i < NUM_LINES; i++) prioVal[i] <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlEn <= wrData[1:0];
      enBits    <= enNext;
      latchBits <= latchNext;
      actBits   <= actNext;
      grpBits   <= grpNext;
      edgeSel   <= edgeNext;
      for (int i = 0; i < NUM_LINES; i++) prioVal[i] <= prioNext[i];
    end
  end

  // readback word views
  logic [31:0] grpWord  [WORDS32];
  logic [31:0] enWord   [WORDS32];
  logic [31:0] pendWord [WORDS32];
  logic [31:0] actWord  [WORDS32];
  logic [31:0] prioWord [PRIO_WORDS];
  logic [31:0] cfgWord  [CFG_WORDS];

  for (genvar j = 0; j < WORDS32; j++) begin : gWord
    assign grpWord[j]  = grpBits[j*32 +: 32];
    assign enWord[j]   = enBits[j*32 +: 32];
    assign pendWord[j] = pendBits[j*32 +: 32];
    assign actWord[j]  = actBits[j*32 +: 32];
  end

  for (genvar j = 0; j < PRIO_WORDS; j++) begin : gPrioWord
    for (genvar k = 0; k < 4; k++) begin : gLane
      assign prioWord[j][k*8 +: 8] = {3'b000, prioVal[j*4 + k]};
    end
  end

  for (genvar j = 0; j < CFG_WORDS; j++) begin : gCfgWord
    for (genvar k = 0; k < 16; k++) begin : gField
      assign cfgWord[j][k*2 +: 2] = {edgeSel[j*16 + k], 1'b0};
    end
  end

  logic [31:0] rdNext;

  always_comb begin
    rdNext = '0;
    case (strobe.rdRegion)
      RG_CTRL: rdNext = {30'b0, ctrlEn};
      RG_GROUP:
        for (int j = 0; j < WORDS32; j++) if (strobe.word == 6'(j)) rdNext = grpWord[j];
      RG_SETEN, RG_CLREN:
        for (int j = 0; j < WORDS32; j++) if (strobe.word == 6'(j)) rdNext = enWord[j];
      RG_SETPEND, RG_CLRPEND:
        for (int j = 0; j < WORDS32; j++) if (strobe.word == 6'(j)) rdNext = pendWord[j];
      RG_SETACT, RG_CLRACT:
        for (int j = 0; j < WORDS32; j++) if (strobe.word == 6'(j)) rdNext = actWord[j];
      RG_PRIO:
        for (int j = 0; j < PRIO_WORDS; j++) if (strobe.word == 6'(j)) rdNext = prioWord[j];
      RG_CFG:
        for (int j = 0; j < CFG_WORDS; j++) if (strobe.word == 6'(j)) rdNext = cfgWord[j];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/intr_dist_arbiter.sv
module intr_dist_arbiter #(
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] enBits,
  input  logic [NUM_LINES-1:0] pendBits,
  input  logic [NUM_LINES-1:0] actBits,
  input  logic [NUM_LINES-1:0] grpBits,
  input  logic [4:0]           prioVal [NUM_LINES],
  input  logic [1:0]           ctrlEn,
  output logic                 fiqReq,
  output logic [ID_W-1:0]      fiqId,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId
);

  for (genvar g = 0; g < 2; g++) begin : gGroup
    logic [NUM_LINES-1:0] cand;
    logic                 found;
    logic [4:0]           best;
    logic [ID_W-1:0]      winId;
    logic                 reqQ;
    logic [ID_W-1:0]      idQ;

    assign cand = enBits & pendBits & ~actBits & ((g == 1) ? grpBits : ~grpBits);

    // ascending scan with strict compare keeps the lowest ID on ties
    always_comb begin
      found = 1'b0;
      best  = '1;
      winId = '1;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (cand[i] && (!found || (prioVal[i] < best))) begin
          found = 1'b1;
          best  = prioVal[i];
          winId = ID_W'(i);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ <= 1'b0;
        idQ  <= '1;
      end else begin
        reqQ <= found & ctrlEn[g];
        idQ  <= (found & ctrlEn[g]) ? winId : '1;
      end
    end
  end

  assign fiqReq = gGroup[0].reqQ;
  assign fiqId  = gGroup[0].idQ;
  assign irqReq = gGroup[1].reqQ;
  assign irqId  = gGroup[1].idQ;

endmodule

// File: rtl/intr_distributor.sv
module intr_distributor
  import intr_dist_pkg::*;
#(
  parameter int NUM_LINES   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W       = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [9:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 ackValid,
  input  logic                 ackGroup,
  input  logic                 eoiValid,
  input  logic [ID_W-1:0]      eoiId,
  output logic                 fiqReq,
  output logic [ID_W-1:0]      fiqId,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId
);

  regStrobeT            strobe;
  logic [1:0]           ctrlEn;
  logic [NUM_LINES-1:0] enBits, pendBits, actBits, grpBits;
  logic [4:0]           prioVal [NUM_LINES];

  intr_dist_ctrl #(.ID_W(ID_W)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .ackValid (ackValid),
    .ackGroup (ackGroup),
    .fiqReq   (fiqReq),
    .fiqId    (fiqId),
    .irqReq   (irqReq),
    .irqId    (irqId),
    .eoiValid (eoiValid),
    .eoiId    (eoiId),
    .strobe   (strobe)
  );

  intr_dist_state #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .strobe   (strobe),
    .wrData   (busWdata),
    .rdData   (busRdata),
    .ctrlEn   (ctrlEn),
    .enBits   (enBits),
    .pendBits (pendBits),
    .actBits  (actBits),
    .grpBits  (grpBits),
    .prioVal  (prioVal)
  );

  intr_dist_arbiter #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) uArbiter (
    .clk      (clk),
    .rstN     (rstN),
    .enBits   (enBits),
    .pendBits (pendBits),
    .actBits  (actBits),
    .grpBits  (grpBits),
    .prioVal  (prioVal),
    .ctrlEn   (ctrlEn),
    .fiqReq   (fiqReq),
    .fiqId    (fiqId),
    .irqReq   (irqReq),
    .irqId    (irqId)
  );

endmodule

// File: rtl/intr_dist_checker.sv
module intr_dist_checker #(
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fiqReq,
  input logic [ID_W-1:0]      fiqId,
  input logic                 irqReq,
  input logic [ID_W-1:0]      irqId,
  input logic                 ackValid,
  input logic                 ackGroup,
  input logic [1:0]           ctrlEn,
  input logic [NUM_LINES-1:0] enBits,
  input logic [NUM_LINES-1:0] actBits
);

  function automatic logic lineBit(input logic [NUM_LINES-1:0] v, input logic [ID_W-1:0] idx);
    return |(v & ({{(NUM_LINES-1){1'b0}}, 1'b1} << idx));
  endfunction

  logic [NUM_LINES-1:0] prevEn, prevAct;
  logic                 prevAckFiq;
  logic [ID_W-1:0]      prevFiqId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEn     <= '0;
      prevAct    <= '0;
      prevAckFiq <= 1'b0;
      prevFiqId  <= '0;
    end else begin
      prevEn     <= enBits;
      prevAct    <= actBits;
      prevAckFiq <= ackValid & ~ackGroup & fiqReq;
      prevFiqId  <= fiqId;
    end
  end

  AST_FIQ_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> (fiqId < ID_W'(NUM_LINES))); // R5
  AST_IRQ_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqId < ID_W'(NUM_LINES))); // R5
  AST_GROUP0_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn[0] |=> (!fiqReq && (fiqId == '1))); // R6
  AST_GROUP1_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn[1] |=> (!irqReq && (irqId == '1))); // R6
  AST_FIQ_LINE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> lineBit(prevEn, fiqId)); // R12
  AST_IRQ_LINE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> lineBit(prevEn, irqId)); // R12
  AST_FIQ_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    fiqReq |-> !lineBit(prevAct, fiqId)); // R9
  AST_IRQ_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !lineBit(prevAct, irqId)); // R9
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rstN)
    prevAckFiq |-> lineBit(actBits, prevFiqId)); // R9

endmodule

bind intr_distributor intr_dist_checker #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .fiqReq   (fiqReq),
  .fiqId    (fiqId),
  .irqReq   (irqReq),
  .irqId    (irqId),
  .ackValid (ackValid),
  .ackGroup (ackGroup),
  .ctrlEn   (uDatapath.ctrlEn),
  .enBits   (uDatapath.enBits),
  .actBits  (uDatapath.actBits)
);

// File: tb/intr_distributor_test.sv
module intr_distributor_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;
  localparam int IW = 7;
  localparam logic [3:0] A_CTRL = 4'd0, A_GRP = 4'd1, A_SEN = 4'd2, A_CEN = 4'd3,
                         A_SPD = 4'd4, A_CPD = 4'd5, A_SAC = 4'd6, A_CAC = 4'd7,
                         A_PRI = 4'd8, A_CFG = 4'd9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] irqIn = '0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic ackValid = 1'b0, ackGroup = 1'b0, eoiValid = 1'b0;
  logic [IW-1:0] eoiId = '0;
  logic fiqReq, irqReq;
  logic [IW-1:0] fiqId, irqId;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_distributor #(.NUM_LINES(NL)) uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .ackValid(ackValid), .ackGroup(ackGroup),
    .eoiValid(eoiValid), .eoiId(eoiId),
    .fiqReq(fiqReq), .fiqId(fiqId), .irqReq(irqReq), .irqId(irqId)
  );

  task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irqIn = '0; busValid = 0; ackValid = 0; eoiValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] region, input logic [5:0] word, input logic [31:0] data);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = {region, word}; busWdata = data;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rdReg(input logic [3:0] region, input logic [5:0] word, output logic [31:0] data);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = {region, word};
    @(negedge clk);
    busValid = 0;
    data = busRdata;
  endtask

  task automatic ack(input logic grp);
    @(negedge clk);
    ackValid = 1; ackGroup = grp;
    @(negedge clk);
    ackValid = 0;
  endtask

  task automatic eoi(input logic [IW-1:0] id);
    @(negedge clk);
    eoiValid = 1; eoiId = id;
    @(negedge clk);
    eoiValid = 0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 fiqReq", 32'(fiqReq), 0);
    check("R1 fiqId", 32'(fiqId), 127);
    check("R1 irqReq", 32'(irqReq), 0);
    check("R1 irqId", 32'(irqId), 127);
    rdReg(A_SEN, 0, rd); check("R1 enable word0", rd, 0);
    rdReg(A_SPD, 1, rd); check("R1 pending word1", rd, 0);
    rdReg(A_PRI, 0, rd); check("R1 priority word0", rd, 0);
  endtask

  task automatic testEnable();
    doReset();
    wr(A_SEN, 0, 32'h5);
    rdReg(A_CEN, 0, rd); check("R2 read via clear reg", rd, 32'h5);
    wr(A_SEN, 0, 32'h0);
    rdReg(A_SEN, 0, rd); check("R2 zero write no effect", rd, 32'h5);
    wr(A_CEN, 0, 32'h4);
    rdReg(A_SEN, 0, rd); check("R2 clear one bit", rd, 32'h1);
    wr(A_SEN, 1, 32'h8000_0000);
    rdReg(A_CEN, 1, rd); check("R2 line 63", rd, 32'h8000_0000);
  endtask

  task automatic testPendAct();
    doReset();
    wr(A_SPD, 1, 32'h3);
    rdReg(A_CPD, 1, rd); check("R3 set pending", rd, 32'h3);
    wr(A_CPD, 1, 32'h1);
    rdReg(A_SPD, 1, rd); check("R3 clear pending", rd, 32'h2);
    wr(A_SAC, 0, 32'h100);
    rdReg(A_CAC, 0, rd); check("R3 set active", rd, 32'h100);
    wr(A_CAC, 0, 32'h100);
    rdReg(A_SAC, 0, rd); check("R3 clear active", rd, 32'h0);
  endtask

  task automatic testPrioLayout();
    doReset();
    wr(A_PRI, 2, 32'hE3A1_FF05);
    rdReg(A_PRI, 2, rd); check("R4 lane mask", rd, 32'h0301_1F05);
    wr(A_CTRL, 0, 32'h1);
    wr(A_PRI, 2, 32'h0301_1F05); // line8=5 line9=31 line10=1 line11=3
    wr(A_SEN, 0, 32'h0F00);
    wr(A_SPD, 0, 32'h0F00);
    @(negedge clk);
    check("R4 lane to line winner", 32'(fiqId), 10);
  endtask

  task automatic testLatency();
    doReset();
    wr(A_CTRL, 0, 32'h1);
    wr(A_SEN, 0, 32'h20);
    wr(A_SPD, 0, 32'h20);
    check("R11 not yet", 32'(fiqReq), 0);
    @(negedge clk);
    check("R11 req next edge", 32'(fiqReq), 1);
    check("R11 id", 32'(fiqId), 5);
  endtask

  task automatic testArb();
    doReset();
    wr(A_CTRL, 0, 32'h1);
    wr(A_SEN, 0, 32'h208);
    wr(A_SEN, 1, 32'h100);
    wr(A_PRI, 0, 32'h0A00_0000); // line3 = 10
    wr(A_PRI, 2, 32'h0000_0400); // line9 = 4
    wr(A_PRI, 10, 32'h0000_0004); // line40 = 4
    wr(A_SPD, 0, 32'h208);
    wr(A_SPD, 1, 32'h100);
    @(negedge clk);
    check("R5 tie lowest id", 32'(fiqId), 9);
    wr(A_CPD, 0, 32'h200);
    @(negedge clk);
    check("R5 next best", 32'(fiqId), 40);
    wr(A_PRI, 0, 32'h0200_0000);
    @(negedge clk);
    check("R5 lower value wins", 32'(fiqId), 3);
  endtask

  task automatic testGroup();
    doReset();
    wr(A_CTRL, 0, 32'h3);
    wr(A_SEN, 0, 32'h4);
    wr(A_SEN, 1, 32'h2);
    wr(A_GRP, 1, 32'h2);
    wr(A_SPD, 0, 32'h4);
    wr(A_SPD, 1, 32'h2);
    @(negedge clk);
    check("R6 fiq id", 32'(fiqId), 2);
    check("R6 irq req", 32'(irqReq), 1);
    check("R6 irq id", 32'(irqId), 33);
    wr(A_CTRL, 0, 32'h1);
    @(negedge clk);
    check("R6 irq gated", 32'({irqReq, irqId}), 32'h7F);
    check("R6 fiq kept", 32'({fiqReq, fiqId}), 32'h82);
    wr(A_CTRL, 0, 32'h2);
    @(negedge clk);
    check("R6 fiq gated", 32'({fiqReq, fiqId}), 32'h7F);
    rdReg(A_GRP, 1, rd); check("R6 group readback", rd, 32'h2);
  endtask

  task automatic testEdge();
    doReset();
    wr(A_CFG, 1, 32'hFFFF_FFFF);
    rdReg(A_CFG, 1, rd); check("R7 reserved bit zero", rd, 32'hAAAA_AAAA);
    wr(A_CFG, 0, 32'h0020_0000); // line 10 edge
    @(negedge clk); irqIn[10] = 1'b1;
    @(negedge clk); irqIn[10] = 1'b0;
    repeat (5) @(negedge clk);
    rdReg(A_SPD, 0, rd); check("R7 edge latched", rd, 32'h400);
    wr(A_CPD, 0, 32'h400);
    rdReg(A_SPD, 0, rd); check("R7 edge clear", rd, 32'h0);
  endtask

  task automatic testLevel();
    doReset();
    wr(A_CTRL, 0, 32'h1);
    wr(A_SEN, 0, 32'h800);
    @(negedge clk); irqIn[11] = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(A_SPD, 0, rd); check("R8 level pending", rd, 32'h800);
    check("R8 level request", 32'({fiqReq, fiqId}), 32'h8B);
    wr(A_CPD, 0, 32'h800);
    rdReg(A_SPD, 0, rd); check("R8 clear while high", rd, 32'h800);
    irqIn[11] = 1'b0;
    repeat (4) @(negedge clk);
    rdReg(A_SPD, 0, rd); check("R8 drop clears", rd, 32'h0);
  endtask

  task automatic testAck();
    doReset();
    wr(A_CTRL, 0, 32'h1);
    wr(A_SEN, 0, 32'h208);
    wr(A_PRI, 0, 32'h0200_0000);
    wr(A_PRI, 2, 32'h0000_0400);
    wr(A_SPD, 0, 32'h208);
    @(negedge clk);
    check("R9 before ack", 32'(fiqId), 3);
    ack(1'b0);
    @(negedge clk);
    check("R9 next after ack", 32'(fiqId), 9);
    rdReg(A_SAC, 0, rd); check("R9 active set", rd, 32'h8);
    rdReg(A_SPD, 0, rd); check("R9 pending cleared", rd, 32'h200);
    wr(A_SPD, 0, 32'h8);
    @(negedge clk);
    check("R9 active held back", 32'(fiqId), 9);
    eoi(7'd3);
    @(negedge clk);
    check("R10 offered after eoi", 32'(fiqId), 3);
    rdReg(A_SAC, 0, rd); check("R10 active cleared", rd, 32'h0);
  endtask

  task automatic testDisabled();
    doReset();
    wr(A_CTRL, 0, 32'h1);
    wr(A_SPD, 0, 32'h80);
    repeat (2) @(negedge clk);
    check("R12 disabled no req", 32'({fiqReq, fiqId}), 32'h7F);
    rdReg(A_SPD, 0, rd); check("R12 still pending", rd, 32'h80);
    wr(A_SEN, 0, 32'h80);
    @(negedge clk);
    check("R12 enabled offered", 32'({fiqReq, fiqId}), 32'h87);
  endtask

  bit done = 0;

  initial begin
    testReset();
    testEnable();
    testPendAct();
    testPrioLayout();
    testLatency();
    testArb();
    testGroup();
    testEdge();
    testLevel();
    testAck();
    testDisabled();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule